// File: doc/BRIEF.md
# UART Receive Queue with In-Band Overrun Tags

This block is the receive side of an asynchronous serial link. A receiver locks its bit timing to the falling edge of each start bit, counts 16 oversampling ticks per bit, samples every bit at its middle and assembles 8-bit characters (no parity, one stop bit). Every character lands in a 16-entry queue as a 10-bit entry: the data byte plus two flag bits. The consumer drains the queue through a valid/ready output.

The ready-to-receive output tells the far-end transmitter whether more characters are welcome. It drops well before the queue is full, so characters already on the wire, or sent before the far end notices the change, still find room. It comes back only after the queue has drained below a lower mark, which gives it hysteresis. If the far end ignores the signal and a character completes while the queue is full, that character is dropped. The next character that is stored carries a tag saying data was lost just before it. This lets the consumer see exactly where a message boundary has become ambiguous.

Top module: `uart_rxq_top`

## Requirements
- R1: After reset, `rts_o` is 1 and `ent_valid_o` is 0.
- R2: A frame on `rx_i` (low start bit, 8 data bits LSB first, high stop bit, 16 clock ticks per bit at the defaults) produces an entry with bits [7:0] = the data byte, bit 8 = 0 and bit 9 = 0. Entries leave in arrival order, and one entry is removed in each cycle where `ent_valid_o` and `ent_ready_i` are both 1.
- R3: When the sampled stop bit is 0, the entry is still stored, with bit 8 (framing error) set to 1.
- R4: A low pulse on `rx_i` that is high again at the middle of the start bit produces no entry.
- R5: `rts_o` goes to 0 once occupancy reaches DEPTH-SLACK (12 of 16). At least SLACK further characters are then stored without loss.
- R6: Once low, `rts_o` stays 0 while occupancy is at or above RESUME (8). It returns to 1 only after occupancy has fallen below RESUME.
- R7: A character that completes while the queue holds DEPTH entries is discarded. The next character that is stored has bit 9 (overrun) set to 1.
- R8: The overrun tag is consumed by the entry that carries it, so later entries have bit 9 = 0.
- R9: While `ent_valid_o` is 1 and `ent_ready_i` is 0, the presented entry stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle is one oversampling tick at the defaults |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| rts_o | output | 1 | Ready-to-receive level toward the far-end transmitter |
| ent_valid_o | output | 1 | Queue head entry is available |
| ent_ready_i | input | 1 | Consumer takes the head entry this cycle |
| ent_data_o | output | 10 | Head entry: [9] overrun before this entry, [8] framing error, [7:0] data |

## Verification
The hardest situation to reach from the ports is the overrun tag. The queue must be completely full, characters must keep arriving after ready-to-receive has already fallen, and the tag must then land on the right later character. The stimulus holds the consumer off and streams sixteen characters, which also walks ready-to-receive through its falling threshold. It then sends two more characters that must vanish. Next it releases exactly enough entries to sit between the two thresholds, and then enough to fall below the lower one. The character sent after that is the one expected to carry the tag, and the character after it is expected to be clean.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef struct packed {
        logic       ovr;   // characters were lost just before this one
        logic       ferr;  // stop bit sampled low
        logic [7:0] data;
    } rxq_ent_t;

    localparam int ENT_W = $bits(rxq_ent_t);

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic rxq_ent_t mk_ent(input logic ovr, input logic ferr,
                                        input logic [7:0] data);
        rxq_ent_t e;
        e.ovr  = ovr;
        e.ferr = ferr;
        e.data = data;
        return e;
    endfunction

endpackage

// File: rtl/uart_rxq_rx.sv
module uart_rxq_rx
    import uart_rxq_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DIV = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o,
    output logic       ferr_o
);
    localparam int CW = $clog2(OSR);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

    logic [1:0]    sync_q;
    logic          rx_s;
    logic          rx_prev_q;
    logic          tick;
    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    bidx_q;
    logic [7:0]    shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 2'b11;
            rx_prev_q <= 1'b1;
        end else begin
            sync_q    <= {sync_q[0], rx_i};
            rx_prev_q <= rx_s;
        end
    end
    assign rx_s = sync_q[1];

    generate
        if (DIV > 1) begin : g_div
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || div_q == DW'(DIV - 1)) div_q <= '0;
                else                              div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DW'(DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RX_IDLE;
            cnt_q      <= '0;
            bidx_q     <= '0;
            shreg_q    <= '0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
            ferr_o     <= 1'b0;
        end else begin
            byte_vld_o <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (rx_prev_q && !rx_s) begin
                        state_q <= RX_START;
                        cnt_q   <= '0;
                    end
                end
                RX_START: if (tick) begin
                    if (cnt_q == MID_C) begin
                        cnt_q  <= '0;
                        bidx_q <= '0;
                        state_q <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: if (tick) begin
                    if (cnt_q == LAST_C) begin
                        cnt_q   <= '0;
                        shreg_q <= {rx_s, shreg_q[7:1]};
                        if (bidx_q == 3'd7) state_q <= RX_STOP;
                        else                bidx_q  <= bidx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (cnt_q == LAST_C) begin
                        byte_vld_o <= 1'b1;
                        byte_o     <= shreg_q;
                        ferr_o     <= !rx_s;
                        state_q    <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_START && tick && cnt_q == MID_C && rx_s) |=> (state_q == RX_IDLE && !byte_vld_o)); // R4

endmodule

// File: rtl/uart_rxq_fifo.sv
module uart_rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_i,
    input  logic [W-1:0]               din_i,
    input  logic                       pop_i,
    output logic [W-1:0]               dout_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop;

    assign do_pop = pop_i && (cnt_q != '0);

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) begin
                mem_q[wr_q] <= din_i;
                wr_q        <= nxt(wr_q);
            end
            if (do_pop) rd_q <= nxt(rd_q);
            if (push_i && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (!push_i && do_pop) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign dout_o  = mem_q[rd_q];
    assign count_o = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push_i |-> (cnt_q != CW'(DEPTH))); // R7

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !pop_i) |=> (cnt_q != '0 && $stable(dout_o))); // R9

endmodule

// File: rtl/uart_rxq_flow.sv
module uart_rxq_flow #(
    parameter int DEPTH  = 16,
    parameter int SLACK  = 4,
    parameter int RESUME = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] count_i,
    output logic                       rts_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] STOP_AT  = CW'(DEPTH - SLACK);
    localparam logic [CW-1:0] GO_BELOW = CW'(RESUME);

    always_ff @(posedge clk) begin
        if (rst)                        rts_o <= 1'b1;
        else if (count_i >= STOP_AT)    rts_o <= 1'b0;
        else if (count_i < GO_BELOW)    rts_o <= 1'b1;
    end

    AST_RTS_DROP: assert property (@(posedge clk) disable iff (rst)
        (count_i >= STOP_AT) |=> !rts_o); // R5

    AST_RTS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rts_o && count_i >= GO_BELOW) |=> !rts_o); // R6

endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
    import uart_rxq_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DIV    = 1,
    parameter int DEPTH  = 16,
    parameter int SLACK  = 4,
    parameter int RESUME = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_i,
    output logic             rts_o,
    output logic             ent_valid_o,
    input  logic             ent_ready_i,
    output logic [ENT_W-1:0] ent_data_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          byte_vld;
    logic [7:0]    byte_d;
    logic          ferr;
    logic [CW-1:0] count;
    logic          full;
    logic          push;
    logic          pend_q;
    rxq_ent_t      wr_ent;

    uart_rxq_rx #(.OSR(OSR), .DIV(DIV)) u_rx (
        .clk(clk), .rst(rst), .rx_i(rx_i),
        .byte_vld_o(byte_vld), .byte_o(byte_d), .ferr_o(ferr)
    );

    assign full   = (count == CW'(DEPTH));
    assign push   = byte_vld && !full;
    assign wr_ent = mk_ent(pend_q, ferr, byte_d);

    always_ff @(posedge clk) begin
        if (rst)           pend_q <= 1'b0;
        else if (byte_vld) pend_q <= full;
    end

    uart_rxq_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push_i(push), .din_i(wr_ent),
        .pop_i(ent_valid_o && ent_ready_i),
        .dout_o(ent_data_o), .count_o(count)
    );

    assign ent_valid_o = (count != '0);

    uart_rxq_flow #(.DEPTH(DEPTH), .SLACK(SLACK), .RESUME(RESUME)) u_flow (
        .clk(clk), .rst(rst), .count_i(count), .rts_o(rts_o)
    );

    AST_TAG_CARRY: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && full) |=> (pend_q && !push)); // R7

    AST_TAG_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (push && pend_q) |=> !pend_q); // R8

endmodule

// File: tb/sim_uart_rxq_top.sv
module sim_uart_rxq_top;
    localparam int BIT = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx  = 1'b1;
    logic       rts;
    logic       vld;
    logic       rdy = 1'b0;
    logic [9:0] dat;

    int checks = 0;
    int errors = 0;
    logic [9:0] expq [$];
    string      tagq [$];

    always #10 clk = ~clk;

    uart_rxq_top u0 (
        .clk(clk), .rst(rst), .rx_i(rx), .rts_o(rts),
        .ent_valid_o(vld), .ent_ready_i(rdy), .ent_data_o(dat)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input logic stop);
        @(negedge clk);
        rx = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = d[i];
            repeat (BIT) @(negedge clk);
        end
        rx = stop;
        repeat (BIT) @(negedge clk);
        rx = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic expect_ent(input logic ovr, input logic ferr, input logic [7:0] d,
                              input string tag);
        expq.push_back({ovr, ferr, d});
        tagq.push_back(tag);
    endtask

    task automatic pop_n(input int n);
        @(negedge clk);
        rdy = 1'b1;
        repeat (n) @(negedge clk);
        rdy = 1'b0;
    endtask

    // monitor: compare each handed-over entry against the scoreboard
    always @(negedge clk) begin
        #5;
        if (!rst && vld && rdy) begin
            if (expq.size() == 0) begin
                check(1'b0, "R4 unexpected entry", int'(dat), 0);
            end else begin
                logic [9:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check(dat == e, t, int'(dat), int'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rts == 1'b1, "R1 rts after reset", int'(rts), 1);
        check(vld == 1'b0, "R1 valid after reset", int'(vld), 0);

        // plain traffic, consumer always ready
        rdy = 1'b1;
        expect_ent(1'b0, 1'b0, 8'h55, "R2 byte 55");
        send_byte(8'h55, 1'b1);
        expect_ent(1'b0, 1'b0, 8'hA3, "R2 byte A3");
        send_byte(8'hA3, 1'b1);
        expect_ent(1'b0, 1'b0, 8'h00, "R2 byte 00");
        send_byte(8'h00, 1'b1);
        expect_ent(1'b0, 1'b0, 8'hFF, "R2 byte FF");
        send_byte(8'hFF, 1'b1);

        // framing error
        expect_ent(1'b0, 1'b1, 8'h3C, "R3 framing flag");
        send_byte(8'h3C, 1'b0);
        expect_ent(1'b0, 1'b0, 8'h81, "R3 clean after framing");
        send_byte(8'h81, 1'b1);
        check(expq.size() == 0, "R2 all drained", expq.size(), 0);

        // false start: short low glitch
        @(negedge clk);
        rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (12 * BIT) @(negedge clk);
        check(vld == 1'b0, "R4 no entry from glitch", int'(vld), 0);

        // fill with consumer stalled
        rdy = 1'b0;
        for (int i = 0; i < 11; i++) begin
            expect_ent(1'b0, 1'b0, 8'h10 + 8'(i), "R5 fill");
            send_byte(8'h10 + 8'(i), 1'b1);
        end
        check(rts == 1'b1, "R5 rts still high at 11", int'(rts), 1);
        check(vld == 1'b1 && dat == 10'h010, "R9 head held", int'(dat), 'h010);
        expect_ent(1'b0, 1'b0, 8'h1B, "R5 fill");
        send_byte(8'h1B, 1'b1);
        check(rts == 1'b0, "R5 rts low at 12", int'(rts), 0);
        for (int i = 12; i < 16; i++) begin
            expect_ent(1'b0, 1'b0, 8'h10 + 8'(i), "R5 slack absorbed");
            send_byte(8'h10 + 8'(i), 1'b1);
        end
        // overrun: queue is full, these two vanish
        send_byte(8'hE0, 1'b1);
        send_byte(8'hE1, 1'b1);

        pop_n(6);   // 10 left
        repeat (3) @(negedge clk);
        check(rts == 1'b0, "R6 rts held low at 10", int'(rts), 0);
        pop_n(2);   // 8 left
        repeat (3) @(negedge clk);
        check(rts == 1'b0, "R6 rts held low at 8", int'(rts), 0);
        pop_n(1);   // 7 left
        repeat (3) @(negedge clk);
        check(rts == 1'b1, "R6 rts high below 8", int'(rts), 1);

        expect_ent(1'b1, 1'b0, 8'h77, "R7 overrun tag");
        send_byte(8'h77, 1'b1);
        expect_ent(1'b0, 1'b0, 8'h78, "R8 tag cleared");
        send_byte(8'h78, 1'b1);

        rdy = 1'b1;
        repeat (40) @(negedge clk);
        check(expq.size() == 0, "R7 dropped bytes absent", expq.size(), 0);
        check(vld == 1'b0, "R7 queue empty", int'(vld), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule